// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog timer that advances on a tick strobe from a slow oscillator domain, sampled in the system clock domain. Software drives it through one byte-wide control register. The register holds a timeout flag, an interrupt enable, a change-guard bit, an enable bit and a four-bit period code. A kick input restarts the count. When the count expires, the block raises an interrupt request, asserts a one-cycle reset request, or does both in turn. Which of these happens depends on the two enable bits.

Turning the watchdog off or changing its period needs a short unlock sequence. The first write sets both the guard bit and the enable bit. The guard then stays open for four clocks. Only a write made during those four clocks may clear the enable bit or load a new period code. Two lock conditions come from a safety-level input and a stored watchdog-reset flag, and they can keep the watchdog switched on regardless of software.

Top module: `watchdog_unit`

## Requirements
- R1: After reset the control register reads 0x00, and both irqReq and resetReq are low.
- R2: The control register bit fields are: bit 7 = timeout flag, bit 6 = interrupt enable, bit 5 = period code bit 3, bit 4 = guard open, bit 3 = enable, bits 2:0 = period code bits 2..0.
- R3: When both the enable bit and the interrupt enable are 0, the counter is stopped and neither request ever asserts.
- R4: A timeout occurs BASE_TICKS × 2^code ticks after a kick, for codes 0 to 9. A kick sets the count back to zero.
- R5: With the interrupt enable set, a timeout sets the flag. irqReq equals flag AND (interrupt enable OR enable). Pulsing irqAck clears the flag, and so does writing 1 to bit 7.
- R6: With the enable set and the interrupt enable clear, a timeout drives resetReq high for exactly one clock, one cycle after the expiring tick.
- R7: With both bits set, the first timeout sets the flag and clears the interrupt enable. The following timeout raises resetReq.
- R8: A write with bits 4 and 3 both set opens the guard. Bit 4 then reads 1 for the next four clocks and 0 after that. Any other write closes the guard.
- R9: A write can clear the enable bit only while the guard is open. A write of 0 to bit 3 at any other time leaves the enable bit at 1.
- R10: The period code (bits 5 and 2:0) is loaded only by a write made while the guard is open. At other times a write leaves it unchanged.
- R11: Codes 10 to 15 give the same timeout as code 9.
- R12: At safety level 1 with resetFlag high, and at safety levels 2 or 3 regardless of resetFlag, the enable bit is forced to 1 and cannot be cleared.
- R13: Loading a period code that differs from the current one restarts the count from zero at that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Watchdog oscillator tick strobe, one clock wide |
| kick | input | 1 | Restart the timeout count |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write data |
| ctrlOut | output | 8 | Control register read value |
| irqAck | input | 1 | Interrupt acknowledge, clears the flag |
| safetyLevel | input | 2 | Safety level select (0 none, 1 flag-lock, 2 and 3 hard-lock) |
| resetFlag | input | 1 | Stored watchdog-reset flag from the reset status logic |
| irqReq | output | 1 | Timeout interrupt request level |
| resetReq | output | 1 | One-cycle reset request pulse |

## Verification
The hardest case to reach is the second expiry in combined mode. That timeout has to come after the hardware has already cleared the interrupt enable, so the stimulus first arms both bits through the guarded sequence, then clears any stale flag, kicks, and waits through two full periods without touching the register. The guard boundary is also awkward to hit: the bench shortens BASE_TICKS so that periods last only a few clocks, and it samples bit 4 clock by clock after the opening write to see the exact cycle in which the guard closes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic run;      // counter may advance
    logic restart;  // force count back to zero
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 2048,
  parameter int MAX_CODE   = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  wdogStrobe_t       strobe,
  input  logic [CODE_W-1:0] presCode,
  output logic              timeout
);
  localparam int MAX_LIMIT = BASE_TICKS << MAX_CODE;
  localparam int CNT_W     = $clog2(MAX_LIMIT) + 1;
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_CODE);

  logic [CNT_W-1:0]  count;
  logic [CODE_W-1:0] effCode;
  logic [CNT_W-1:0]  lastCount;

  // reserved codes fold onto the longest period
  assign effCode   = (presCode > TOP_CODE) ? TOP_CODE : presCode;
  assign lastCount = (CNT_W'(BASE_TICKS) << effCode) - CNT_W'(1);
  assign timeout   = strobe.run && !strobe.restart && tick && (count == lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.restart) begin
      count <= '0;
    end else if (strobe.run && tick) begin
      count <= timeout ? '0 : count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CE_WINDOW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              kick,
  input  logic              irqAck,
  input  logic [1:0]        safetyLevel,
  input  logic              resetFlag,
  input  logic              timeout,
  output logic [7:0]        ctrlOut,
  output logic              irqReq,
  output logic              resetReq,
  output wdogStrobe_t       strobe,
  output logic [CODE_W-1:0] presCode
);
  localparam int CE_W = $clog2(CE_WINDOW + 1);

  logic            flagQ, irqEnQ, enQ, resetQ;
  logic [CODE_W-1:0] presQ;
  logic [CE_W-1:0] guardCnt;

  logic guardOpen, openWrite, lockOn, presChange;
  logic [CODE_W-1:0] newPres;

  assign guardOpen  = (guardCnt != '0);
  assign openWrite  = wrEn && wrData[4] && wrData[3];
  assign lockOn     = safetyLevel[1] || (safetyLevel == 2'd1 && resetFlag);
  assign newPres    = {wrData[5], wrData[2:0]};
  assign presChange = wrEn && guardOpen && (newPres != presQ);

  assign strobe.run     = enQ || irqEnQ;
  assign strobe.restart = kick || presChange || !(enQ || irqEnQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      irqEnQ   <= 1'b0;
      enQ      <= 1'b0;
      resetQ   <= 1'b0;
      presQ    <= '0;
      guardCnt <= '0;
    end else begin
      // guard window
      if (openWrite)      guardCnt <= CE_W'(CE_WINDOW);
      else if (wrEn)      guardCnt <= '0;
      else if (guardOpen) guardCnt <= guardCnt - CE_W'(1);

      // enable: set freely, cleared only inside the window, forced by locks
      if (lockOn)                      enQ <= 1'b1;
      else if (wrEn && wrData[3])      enQ <= 1'b1;
      else if (wrEn && guardOpen)      enQ <= 1'b0;

      if (wrEn && guardOpen) presQ <= newPres;

      // interrupt enable: software write, auto-clear in combined mode
      if (timeout && irqEnQ && enQ) irqEnQ <= 1'b0;
      else if (wrEn)                irqEnQ <= wrData[6];

      // timeout flag: set wins over clear
      if (timeout && irqEnQ)                    flagQ <= 1'b1;
      else if (irqAck || (wrEn && wrData[7]))   flagQ <= 1'b0;

      resetQ <= timeout && enQ && !irqEnQ;
    end
  end

  assign presCode = presQ;
  assign ctrlOut  = {flagQ, irqEnQ, presQ[3], guardOpen, enQ, presQ[2:0]};
  assign irqReq   = flagQ && (irqEnQ || enQ);
  assign resetReq = resetQ;
endmodule

// File: rtl/watchdog_unit.sv
module watchdog_unit
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 2048,
  parameter int MAX_CODE   = 9,
  parameter int CE_WINDOW  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       kick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] ctrlOut,
  input  logic       irqAck,
  input  logic [1:0] safetyLevel,
  input  logic       resetFlag,
  output logic       irqReq,
  output logic       resetReq
);
  wdogStrobe_t       strobe;
  logic [CODE_W-1:0] presCode;
  logic              timeout;

  wdog_ctrl #(.CE_WINDOW(CE_WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .kick(kick),
    .irqAck(irqAck), .safetyLevel(safetyLevel), .resetFlag(resetFlag),
    .timeout(timeout), .ctrlOut(ctrlOut), .irqReq(irqReq),
    .resetReq(resetReq), .strobe(strobe), .presCode(presCode)
  );

  wdog_count #(.BASE_TICKS(BASE_TICKS), .MAX_CODE(MAX_CODE)) u_count (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .presCode(presCode), .timeout(timeout)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CE_WINDOW = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] ctrlOut,
  input logic [1:0] safetyLevel,
  input logic       resetReq
);
  logic [7:0] guardRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    guardRun <= '0;
    else if (ctrlOut[4] && !wrEn) guardRun <= (guardRun == 8'hFF) ? guardRun : guardRun + 8'd1;
    else                          guardRun <= '0;
  end

  assert_guard_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    guardRun <= 8'(CE_WINDOW));

  assert_enable_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlOut[3]) |-> $past(ctrlOut[4]));

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOut[4] |=> $stable({ctrlOut[5], ctrlOut[2:0]}));

  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_reset_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(ctrlOut[3]));

  assert_hard_lock_R12: assert property (@(posedge clk) disable iff (!rstN)
    safetyLevel[1] |=> ctrlOut[3]);
endmodule

bind watchdog_unit wdog_checker #(.CE_WINDOW(CE_WINDOW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .ctrlOut(ctrlOut),
  .safetyLevel(safetyLevel), .resetReq(resetReq)
);

// File: tb/watchdog_unit_test.sv
module watchdog_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] ctrlOut;
  logic       irqAck = 1'b0;
  logic [1:0] safetyLevel = 2'd0;
  logic       resetFlag = 1'b0;
  logic       irqReq, resetReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  watchdog_unit #(.BASE_TICKS(4), .MAX_CODE(9), .CE_WINDOW(4)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .wrEn(wrEn),
    .wrData(wrData), .ctrlOut(ctrlOut), .irqAck(irqAck),
    .safetyLevel(safetyLevel), .resetFlag(resetFlag),
    .irqReq(irqReq), .resetReq(resetReq)
  );

  // table: period code and expected ticks from kick to flag (BASE_TICKS = 4)
  localparam logic [3:0] VEC_CODE [0:5] = '{4'd0, 4'd1, 4'd3, 4'd5, 4'd9, 4'd12};
  localparam int         VEC_LEN  [0:5] = '{4, 8, 32, 128, 2048, 2048};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  task automatic openGuard();
    wr((ctrlOut & 8'h6F) | 8'h18);
  endtask

  task automatic setMode(input bit ie, input bit en, input logic [3:0] code);
    openGuard();
    wr({1'b0, ie, code[3], 1'b0, en, code[2:0]});
  endtask

  task automatic pulseKick();
    kick = 1'b1; step(); kick = 1'b0;
  endtask

  task automatic pulseAck();
    irqAck = 1'b1; step(); irqAck = 1'b0;
  endtask

  task automatic waitIrq(input int limit, output int n);
    n = 0;
    do begin step(); n++; end while (!irqReq && n < limit);
  endtask

  task automatic waitRst(input int limit, output int n);
    n = 0;
    do begin step(); n++; end while (!resetReq && n < limit);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();

    // R1 reset state
    check(ctrlOut == 8'h00, "R1 ctrlOut", ctrlOut, 0);
    check(!irqReq && !resetReq, "R1 requests", {irqReq, resetReq}, 0);

    // R3 stopped: no request for a long stretch
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin step(); seen |= irqReq | resetReq; end
    check(!seen, "R3 stopped", seen, 0);

    // R8 guard window: four cycles open, then closed
    wr(8'h18);
    for (int i = 0; i < 4; i++) begin
      check(ctrlOut[4] == 1'b1, "R8 guard open", ctrlOut[4], 1);
      if (i < 3) step();
    end
    step();
    check(ctrlOut[4] == 1'b0, "R8 guard closed", ctrlOut[4], 0);

    // R9 clear outside window ignored, inside window accepted
    wr(8'h00);
    check(ctrlOut[3] == 1'b1, "R9 clear outside window", ctrlOut[3], 1);
    openGuard();
    wr(8'h00);
    check(ctrlOut[3] == 1'b0, "R9 clear inside window", ctrlOut[3], 0);

    // R10 code write outside window ignored
    wr(8'h27);
    check({ctrlOut[5], ctrlOut[2:0]} == 4'd0, "R10 code held", {ctrlOut[5], ctrlOut[2:0]}, 0);

    // R4 / R11 / R2 table walk in interrupt mode
    for (int v = 0; v < 6; v++) begin
      setMode(1'b1, 1'b0, VEC_CODE[v]);
      check({ctrlOut[5], ctrlOut[2:0]} == VEC_CODE[v], "R2 code field",
            {ctrlOut[5], ctrlOut[2:0]}, VEC_CODE[v]);
      pulseAck();
      pulseKick();
      waitIrq(5000, n);
      check(n == VEC_LEN[v], (VEC_CODE[v] > 9) ? "R11 reserved code period" : "R4 period",
            n, VEC_LEN[v]);
    end

    // R5 clear by writing one to the flag bit
    check(ctrlOut[7] && irqReq, "R5 flag set", {ctrlOut[7], irqReq}, 3);
    wr((ctrlOut & 8'h6F) | 8'h80);
    check(!ctrlOut[7] && !irqReq, "R5 write-one clear", {ctrlOut[7], irqReq}, 0);
    // R5 clear by acknowledge
    setMode(1'b1, 1'b0, 4'd0);
    pulseAck();
    pulseKick();
    waitIrq(100, n);
    check(n == 4, "R5 short period", n, 4);
    pulseAck();
    check(!ctrlOut[7] && !irqReq, "R5 ack clear", {ctrlOut[7], irqReq}, 0);

    // R6 reset mode single pulse
    setMode(1'b0, 1'b1, 4'd1);
    pulseKick();
    waitRst(100, n);
    check(n == 8, "R6 reset timing", n, 8);
    step();
    check(!resetReq, "R6 single pulse", resetReq, 0);
    check(!irqReq, "R6 no interrupt", irqReq, 0);

    // R7 combined mode: interrupt first, reset next
    setMode(1'b1, 1'b1, 4'd1);
    pulseAck();
    pulseKick();
    waitIrq(100, n);
    check(n == 8, "R7 first timeout interrupt", n, 8);
    check(ctrlOut[6] == 1'b0 && ctrlOut[7] == 1'b1, "R7 enable auto-clear", ctrlOut[7:6], 2);
    waitRst(100, n);
    check(n == 8, "R7 second timeout reset", n, 8);

    // R13 period change restarts count
    setMode(1'b1, 1'b0, 4'd2);
    pulseAck();
    pulseKick();
    repeat (6) step();
    openGuard();
    wr({2'b01, 1'b0, 1'b0, 1'b0, 3'd1});
    n = 0;
    while (!irqReq && n < 100) begin step(); n++; end
    check(n == 8, "R13 restart on code change", n, 8);

    // R12 safety level 1 with flag, then level 2
    setMode(1'b0, 1'b0, 4'd9);
    safetyLevel = 2'd1; resetFlag = 1'b1;
    step(); step();
    check(ctrlOut[3], "R12 level1 forced", ctrlOut[3], 1);
    openGuard();
    wr(8'h00);
    check(ctrlOut[3], "R12 level1 no disable", ctrlOut[3], 1);
    resetFlag = 1'b0;
    openGuard();
    wr(8'h00);
    check(!ctrlOut[3], "R12 level1 disable after flag", ctrlOut[3], 0);
    safetyLevel = 2'd2;
    step(); step();
    check(ctrlOut[3], "R12 level2 forced", ctrlOut[3], 1);
    openGuard();
    wr(8'h00);
    check(ctrlOut[3], "R12 level2 no disable", ctrlOut[3], 1);
    safetyLevel = 2'd0;
    openGuard();
    wr(8'h00);
    check(!ctrlOut[3], "R12 level0 disable", ctrlOut[3], 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule